// File: doc/BRIEF.md
# Limit-Compare Periodic Counter Timer

This block is a small counter/timer behind a 32-bit word-register interface. An external prescaler hands it a one-cycle enable every 500 ns. On each enable the counter moves up by one unit, and that unit sits at bit 9 of the counter word. When the next value would equal the programmed limit, the counter goes back to zero on that same tick. At the same moment it latches a reached flag that drives a level interrupt. The interrupt therefore repeats every `limit` ticks. A limit of zero makes the counter run freely over its whole field.

Software services the interrupt by reading the limit word, and that read is the acknowledge. The limit can be loaded at two word offsets. One restarts the count and clears any pending interrupt. The other swaps in a new limit and leaves the count and the flag alone. All reads are registered: the word for a read shows on `bus_rdata` after the clock edge that samples `bus_rd`.

Top module: `lct_timer`

## Requirements
- R1: After reset the stored limit, the count, the reached flag, `irq` and `bus_rdata` are all zero.
- R2: A cycle with `tick_en` high adds one to the count field (bits SHIFT+CNT_BITS-1 down to SHIFT; at the defaults that is bits 30..9, one tick = 0x200). A cycle without `tick_en` leaves the count unchanged. Count bits below SHIFT always read as zero.
- R3: With a nonzero limit L, a tick at count L-1 returns the count to zero on that same tick, sets the reached flag and raises `irq`. Both take effect at the edge of that tick. The flag then repeats every L ticks.
- R4: With a zero limit the counter runs freely. A tick at count all-ones-minus-one returns the count to zero and sets the reached flag, the same way a programmed limit of all ones would.
- R5: Word index = address bits 4..2. A read at index 0 returns the stored limit in place, with every other bit zero. A read at index 1 returns the count field in place, with the reached flag in bit 31.
- R6: A read at index 0 clears the reached flag and drops `irq`. If a limit hit happens in that same cycle, the flag stays set.
- R7: A write at index 0 stores only the write-data bits that fall inside the count field, zeroes the count and clears the reached flag. A tick in the same cycle is overridden.
- R8: A write at index 2 stores the limit the same way. It leaves the reached flag alone, and the count still advances if a tick arrives in that cycle.
- R9: If a write at index 2 leaves the count at or above the new limit, the count runs up to all ones and wraps to zero with no flag. It then hits the new limit normally.
- R10: Reads at indices 3 to 7 return zero. Writes at indices 1 and 3 to 7 change nothing.
- R11: `bus_rdata` changes only at an edge where `bus_rd` is high. It holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | One-cycle count enable from the 500 ns prescaler |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Word index (address bits 4..2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt, high while the reached flag is set |

## Verification
The bench uses a four-bit count field and sweeps every limit value, including the free-run case, over more than two full periods each.
- A design that compares against the count itself rather than the next count would stretch every period by one tick.
- A design that ignored the zero-limit case would never wrap in free-run.

Several same-cycle collisions are aimed at directly:
- A limit hit together with an acknowledge read. A design with the wrong priority loses the interrupt.
- A restarting write together with a tick. A design with the wrong priority leaves the count at one.
- A keep-count write while the flag is pending. A design that treats it as a restart clears the flag.

A limit reloaded below the running count checks the silent overflow wrap. The bench also writes all-ones data to check the field masking, and probes the unused indices for side effects.

// File: rtl/lct_pkg.sv
package lct_pkg;

  // Word index decoded from address bits 4..2
  typedef enum logic [2:0] {
    SEL_LIM_RST  = 3'd0,
    SEL_COUNT    = 3'd1,
    SEL_LIM_KEEP = 3'd2,
    SEL_RSVD3    = 3'd3,
    SEL_RSVD4    = 3'd4,
    SEL_RSVD5    = 3'd5,
    SEL_RSVD6    = 3'd6,
    SEL_RSVD7    = 3'd7
  } sel_e;

  typedef struct packed {
    logic ld_rst;   // write, limit plus restart
    logic ld_keep;  // write, limit only
    logic rd_lim;   // read limit (acknowledge)
    logic rd_cnt;   // read count plus flag
  } strobe_t;

endpackage

// File: rtl/lct_regdec.sv
module lct_regdec
  import lct_pkg::*;
(
  input  logic       wr,
  input  logic       rd,
  input  logic [2:0] idx,
  output strobe_t    stb
);

  sel_e sel;

  always_comb begin
    sel         = sel_e'(idx);
    stb         = '0;
    stb.ld_rst  = wr && (sel == SEL_LIM_RST);
    stb.ld_keep = wr && (sel == SEL_LIM_KEEP);
    stb.rd_lim  = rd && (sel == SEL_LIM_RST);
    stb.rd_cnt  = rd && (sel == SEL_COUNT);
  end

endmodule

// File: rtl/lct_count.sv
module lct_count #(
  parameter int CNT_BITS = 22
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                ld_rst,
  input  logic                ld_keep,
  input  logic [CNT_BITS-1:0] ld_val,
  output logic [CNT_BITS-1:0] cnt_q,
  output logic [CNT_BITS-1:0] lim_q,
  output logic                hit
);

  localparam logic [CNT_BITS-1:0] FULL = '1;

  logic [CNT_BITS-1:0] eff_lim;
  logic [CNT_BITS:0]   sum;
  logic [CNT_BITS-1:0] cnt_d, lim_d;
  logic                cnt_en, lim_en;

  always_comb begin
    eff_lim = (lim_q == '0) ? FULL : lim_q;
    sum     = {1'b0, cnt_q} + 1'b1;
    hit     = tick && !ld_rst && (sum == {1'b0, eff_lim});
    cnt_en  = ld_rst || tick;
    if (ld_rst)   cnt_d = '0;
    else if (hit) cnt_d = '0;
    else          cnt_d = sum[CNT_BITS-1:0];
    lim_en  = ld_rst || ld_keep;
    lim_d   = ld_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lim_q <= '0;
    else if (lim_en) lim_q <= lim_d;
  end

  // R2
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !ld_rst) |=> (cnt_q == '0) || (cnt_q == $past(cnt_q) + 1'b1));
  // R2
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !ld_rst) |=> $stable(cnt_q));
  // R7
  cnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_rst |=> (cnt_q == '0));
  // R3
  cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0));

endmodule

// File: rtl/lct_flag.sv
module lct_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic ack,
  input  logic clr,
  output logic flag_q
);

  logic flag_d, flag_en;

  always_comb begin
    flag_en = set || ack || clr;
    if (clr)      flag_d = 1'b0;
    else if (set) flag_d = 1'b1;
    else          flag_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set && !clr) |=> flag_q);
  // R6
  flag_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !set) |=> !flag_q);
  // R3
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !ack && !clr) |=> $stable(flag_q));

endmodule

// File: rtl/lct_timer.sv
module lct_timer
  import lct_pkg::*;
#(
  parameter int SHIFT    = 9,
  parameter int CNT_BITS = 22
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [4:2]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq
);

  localparam logic [31:0] FIELD_MASK = ((32'd1 << CNT_BITS) - 32'd1) << SHIFT;

  strobe_t             stb;
  logic [CNT_BITS-1:0] ld_val, cnt_q, lim_q;
  logic                hit, flag_q;
  logic [31:0]         lim_word, cnt_word, rd_word;
  logic [31:0]         rdata_q;

  lct_regdec u_dec (
    .wr  (bus_wr),
    .rd  (bus_rd),
    .idx (bus_addr),
    .stb (stb)
  );

  assign ld_val = CNT_BITS'((bus_wdata & FIELD_MASK) >> SHIFT);

  lct_count #(.CNT_BITS(CNT_BITS)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick    (tick_en),
    .ld_rst  (stb.ld_rst),
    .ld_keep (stb.ld_keep),
    .ld_val  (ld_val),
    .cnt_q   (cnt_q),
    .lim_q   (lim_q),
    .hit     (hit)
  );

  lct_flag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (hit),
    .ack    (stb.rd_lim),
    .clr    (stb.ld_rst),
    .flag_q (flag_q)
  );

  always_comb begin
    lim_word = 32'(lim_q) << SHIFT;
    cnt_word = (32'(cnt_q) << SHIFT) | (32'(flag_q) << 31);
    if (stb.rd_lim)      rd_word = lim_word;
    else if (stb.rd_cnt) rd_word = cnt_word;
    else                 rd_word = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata_q <= '0;
    else if (bus_rd) rdata_q <= rd_word;
  end

  assign bus_rdata = rdata_q;
  assign irq       = flag_q;

  // R10
  rd_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr >= 3'd3) |=> (bus_rdata == '0));
  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata));
  // R5
  rd_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0) |=> (bus_rdata == $past(lim_word)));
  // R7
  wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.ld_rst, stb.ld_keep}));
  // R3
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (cnt_q == '0));

endmodule

// File: tb/tb_lct_timer.sv
module tb_lct_timer;

  localparam int SH = 9;
  localparam int CB = 4;
  localparam int FULL = (1 << CB) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [4:2]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // reference state
  int m_cnt = 0;
  int m_lim = 0;
  int m_flag = 0;
  logic [31:0] exp_rd;
  logic [31:0] last_rd;

  always #2 clk = ~clk;

  lct_timer #(.SHIFT(SH), .CNT_BITS(CB)) dut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic int eff_lim();
    return (m_lim == 0) ? FULL : m_lim;
  endfunction

  // one cycle of stimulus; called at a negedge, returns at the next negedge
  task automatic op(input bit tk, input bit wr, input bit rd, input int idx,
                    input logic [31:0] wd);
    bit hit;
    int fld;
    tick_en   = tk;
    bus_wr    = wr;
    bus_rd    = rd;
    bus_addr  = 3'(idx);
    bus_wdata = wd;
    if (rd) begin
      if (idx == 0)      exp_rd = 32'(m_lim) << SH;
      else if (idx == 1) exp_rd = (32'(m_cnt) << SH) | (32'(m_flag) << 31);
      else               exp_rd = 32'h0;
    end
    @(posedge clk);
    fld = int'((wd >> SH) & FULL);
    hit = 0;
    if (wr && idx == 0) begin
      m_lim = fld; m_cnt = 0; m_flag = 0;
    end else begin
      if (tk) begin
        if (m_cnt + 1 == eff_lim()) begin hit = 1; m_cnt = 0; end
        else m_cnt = (m_cnt + 1) % (FULL + 1);
      end
      if (wr && idx == 2) m_lim = fld;
      if (hit) m_flag = 1;
      else if (rd && idx == 0) m_flag = 0;
    end
    @(negedge clk);
    tick_en = 0; bus_wr = 0; bus_rd = 0; bus_addr = '0; bus_wdata = '0;
  endtask

  // read count word and check it with irq
  task automatic peek(input string tag);
    op(0, 0, 1, 1, 32'h0);
    chk({tag, " count word"}, bus_rdata, exp_rd);
    chk({tag, " irq"}, {31'h0, irq}, 32'(m_flag));
  endtask

  task automatic ack_chk(input string tag);
    op(0, 0, 1, 0, 32'h0);
    chk({tag, " R5 limit read"}, bus_rdata, exp_rd);
    chk({tag, " R6 irq after ack"}, {31'h0, irq}, 32'(m_flag));
  endtask

  function automatic logic [31:0] lim_wd(input int l);
    return (32'hFFFF_FFFF & ~(32'(FULL) << SH)) | (32'(l) << SH);
  endfunction

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 irq at reset", {31'h0, irq}, 32'h0);
    chk("R1 rdata at reset", bus_rdata, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    peek("R1");
    ack_chk("R1");

    // R3 R4 R7: every limit, junk outside the field, over two periods
    for (int l = 0; l <= FULL; l++) begin
      op(0, 1, 0, 0, lim_wd(l));
      peek("R7 restart");
      for (int t = 0; t < 2 * ((l == 0) ? FULL : l) + 2; t++) begin
        op(1, 0, 0, 0, 32'h0);
        peek((l == 0) ? "R4 free-run" : "R3 limit");
        if (m_flag != 0 && t > ((l == 0) ? FULL : l)) ack_chk("R3 period");
      end
      ack_chk("R5");
    end

    // R2 stability without tick
    op(0, 1, 0, 0, 32'(5) << SH);
    op(1, 0, 0, 0, 0); op(1, 0, 0, 0, 0);
    for (int i = 0; i < 4; i++) op(0, 0, 0, 0, 0);
    peek("R2 hold");
    chk("R2 count value", bus_rdata, 32'(2) << SH);

    // R7 restart wins over tick
    op(1, 1, 0, 0, 32'(5) << SH);
    peek("R7 tick collision");

    // R6 hit and ack in the same cycle
    op(0, 1, 0, 0, 32'(3) << SH);
    op(1, 0, 0, 0, 0); op(1, 0, 0, 0, 0);
    op(1, 0, 1, 0, 0);
    chk("R6 ack read data", bus_rdata, exp_rd);
    chk("R6 flag survives", {31'h0, irq}, 32'h1);
    peek("R6");
    ack_chk("R6 later ack");

    // R8 keep-count write with flag pending and a tick
    for (int i = 0; i < 3; i++) op(1, 0, 0, 0, 0);
    op(1, 0, 0, 0, 0); op(1, 0, 0, 0, 0);
    op(1, 1, 0, 2, 32'(12) << SH);
    peek("R8 keep");
    chk("R8 flag kept", {31'h0, irq}, 32'h1);
    ack_chk("R8");

    // R9 limit reloaded below the count
    op(0, 1, 0, 0, 32'(12) << SH);
    for (int i = 0; i < 9; i++) op(1, 0, 0, 0, 0);
    op(0, 1, 0, 2, 32'(4) << SH);
    for (int i = 0; i < 12; i++) begin
      op(1, 0, 0, 0, 0);
      peek("R9 overflow wrap");
    end

    // R10 unused indices
    op(0, 1, 0, 0, 32'(7) << SH);
    op(1, 0, 0, 0, 0);
    op(0, 1, 0, 1, 32'hFFFF_FFFF);
    for (int i = 3; i < 8; i++) op(0, 1, 0, i, 32'hFFFF_FFFF);
    peek("R10 writes ignored");
    for (int i = 3; i < 8; i++) begin
      op(0, 0, 1, i, 0);
      chk("R10 reserved read", bus_rdata, 32'h0);
    end
    ack_chk("R10 limit intact");

    // R11 rdata holds without a read
    peek("R11");
    last_rd = bus_rdata;
    op(1, 0, 0, 0, 0); op(1, 0, 0, 0, 0);
    chk("R11 rdata hold", bus_rdata, last_rd);

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

endmodule